// File: doc/BRIEF.md
# Scalar Saturating Multiply-Accumulate Class Decoder

This block sits in the decode path of a 64-bit core and looks at one instruction class: scalar three-register operations that multiply two signed lanes and round the doubled product into an accumulator, either adding it or subtracting it. Each accepted instruction word, together with the feature-enable and access-permission levels sampled alongside it, gives one registered verdict. The word is either outside the class (no flag), undefined, trapped by the access check, or issued to the multiply-accumulate unit. An issued request carries the two source register indices, the destination index (which is also the accumulator source), the element size and the add/subtract select. The register file reads only lane 0 of each named register.

A second path takes the lane result back from the multiply-accumulate unit and forms the destination writeback. The 16-bit or 32-bit lane is zero-extended to the full 64-bit register, so every bit of the destination is rewritten.

Both paths are valid/ready streams with one register stage each. A stage accepts a new item (ready high) whenever it is empty or its output is being taken in the same cycle. While its valid is high and its ready is low, the output holds every bit unchanged. A producer must keep its valid and its data steady until the item is taken.

Top module: `sqx_decoder`

## Requirements
- R1: A word is in the class exactly when (word AND 0xDF208400) equals 0x5E008400; `out_hit` reports this, and for a word outside the class none of `out_undef`, `out_trap`, `out_issue` is set.
- R2: For an issued word the request carries destination index = bits 4:0, first source = bits 9:5, second source = bits 20:16, element size code = bits 23:22 (1 = 16-bit, 2 = 32-bit), and `out_sub` = 1 for the subtracting form.
- R3: A class word whose bit 29 is 0 is undefined, whatever its other fields, feature level or access level.
- R4: The operation field is bits 14:11; value 0 is the adding form, value 1 the subtracting form, and every other value makes the word undefined.
- R5: With a legal bit 29 and operation, a size code of 0 or 3 makes the word undefined.
- R6: A word that passes the field checks while `in_feat_en` is low is undefined.
- R7: The access check is applied only after all encoding checks pass; a failing access (`in_access_ok` low) then gives `out_trap` with neither undefined nor issue.
- R8: For a class word exactly one of undefined, trap and issue is set, and the verdict appears at the output in the cycle after the word is accepted.
- R9: `in_ready` equals (not `out_valid`) or `out_ready`; while `out_valid` is high and `out_ready` low, all decode outputs hold their values.
- R10: The writeback data is the lane result zero-extended to 64 bits: with size code 1 only bits 15:0 of the lane are kept; with any other code bits 31:0 are kept; all higher bits are 0, and `wb_rd` equals the tagged destination index.
- R11: `res_ready` equals (not `wb_valid`) or `wb_ready`; a taken result shows up on `wb_valid` in the next cycle and holds while `wb_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction word offered |
| in_ready | output | 1 | Decode stage can take a word |
| in_insn | input | 32 | Instruction word |
| in_feat_en | input | 1 | Feature enable for this class |
| in_access_ok | input | 1 | Access permission for SIMD registers |
| out_valid | output | 1 | Verdict present |
| out_ready | input | 1 | Consumer takes the verdict |
| out_hit | output | 1 | Word is in the class |
| out_undef | output | 1 | Undefined encoding |
| out_trap | output | 1 | Access check failed |
| out_issue | output | 1 | Request to the multiply-accumulate unit |
| out_rd | output | 5 | Destination and accumulator index |
| out_rn | output | 5 | First source index |
| out_rm | output | 5 | Second source index |
| out_esize | output | 2 | Element size code |
| out_sub | output | 1 | Subtracting form |
| res_valid | input | 1 | Lane result offered |
| res_ready | output | 1 | Writeback stage can take a result |
| res_rd | input | 5 | Destination index of the result |
| res_esize | input | 2 | Element size code of the result |
| res_data | input | 32 | Lane result |
| wb_valid | output | 1 | Writeback present |
| wb_ready | input | 1 | Register file takes the writeback |
| wb_rd | output | 5 | Writeback register index |
| wb_data | output | 64 | Zero-extended register value |

## Verification
Directed words walk the rejection order one fault at a time, then in pairs (bit 29 clear with a failing access, feature off with a failing access), so that a reordered or missing check changes the verdict. Words that differ from the class pattern in a single fixed bit, plus an all-zero word, separate the class match from the field checks. Random class words with random fields, feature and access levels, mixed with fully random words, exercise the verdict priority broadly. Both streams run under bursts of light and heavy back-pressure; the two size codes on the result path tell a 16-bit mask from a 32-bit one.

// File: rtl/sqx_pkg.sv
package sqx_pkg;

  localparam int unsigned INSN_W = 32;
  localparam int unsigned RIDX_W = 5;
  localparam int unsigned OPC_W  = 4;
  localparam int unsigned SZ_W   = 2;

  localparam logic [INSN_W-1:0] CLASS_MASK  = 32'hDF20_8400;
  localparam logic [INSN_W-1:0] CLASS_MATCH = 32'h5E00_8400;

  // field positions fixed by the instruction encoding
  localparam int unsigned POS_RD  = 0;
  localparam int unsigned POS_RN  = 5;
  localparam int unsigned POS_OPC = 11;
  localparam int unsigned POS_RM  = 16;
  localparam int unsigned POS_SZ  = 22;
  localparam int unsigned POS_U   = 29;

  localparam logic [SZ_W-1:0]  SZ_HALF = 2'd1;
  localparam logic [SZ_W-1:0]  SZ_WORD = 2'd2;
  localparam logic [OPC_W-1:0] OPC_ACC_ADD = 4'd0;
  localparam logic [OPC_W-1:0] OPC_ACC_SUB = 4'd1;

  typedef enum logic [1:0] {
    VERD_NONE  = 2'd0,
    VERD_UNDEF = 2'd1,
    VERD_TRAP  = 2'd2,
    VERD_ISSUE = 2'd3
  } verdict_e;

  typedef struct packed {
    logic              ubit;
    logic [SZ_W-1:0]   sz;
    logic [RIDX_W-1:0] rm;
    logic [OPC_W-1:0]  opc;
    logic [RIDX_W-1:0] rn;
    logic [RIDX_W-1:0] rd;
  } fields_t;

  typedef struct packed {
    logic              hit;
    logic              undef;
    logic              trap;
    logic              issue;
    logic [RIDX_W-1:0] rd;
    logic [RIDX_W-1:0] rn;
    logic [RIDX_W-1:0] rm;
    logic [SZ_W-1:0]   sz;
    logic              sub;
  } verdict_t;

endpackage

// File: rtl/sqx_field_split.sv
module sqx_field_split
  import sqx_pkg::*;
(
  input  logic [INSN_W-1:0] insn,
  output logic              hit,
  output fields_t           f
);

  always_comb begin
    hit    = (insn & CLASS_MASK) == CLASS_MATCH;
    f.rd   = insn[POS_RD  +: RIDX_W];
    f.rn   = insn[POS_RN  +: RIDX_W];
    f.opc  = insn[POS_OPC +: OPC_W];
    f.rm   = insn[POS_RM  +: RIDX_W];
    f.sz   = insn[POS_SZ  +: SZ_W];
    f.ubit = insn[POS_U];
  end

endmodule

// File: rtl/sqx_legal_chain.sv
module sqx_legal_chain
  import sqx_pkg::*;
(
  input  logic     hit,
  input  fields_t  f,
  input  logic     feat_en,
  input  logic     access_ok,
  output verdict_e verdict,
  output logic     sub
);

  logic opc_known;
  logic sz_known;

  always_comb begin
    opc_known = (f.opc == OPC_ACC_ADD) || (f.opc == OPC_ACC_SUB);
    sz_known  = (f.sz == SZ_HALF) || (f.sz == SZ_WORD);
    sub       = (f.opc == OPC_ACC_SUB);
  end

  // ordered rejection: class, U bit, operation, size, feature, access
  always_comb begin
    if (!hit)             verdict = VERD_NONE;
    else if (!f.ubit)     verdict = VERD_UNDEF;
    else if (!opc_known)  verdict = VERD_UNDEF;
    else if (!sz_known)   verdict = VERD_UNDEF;
    else if (!feat_en)    verdict = VERD_UNDEF;
    else if (!access_ok)  verdict = VERD_TRAP;
    else                  verdict = VERD_ISSUE;
  end

endmodule

// File: rtl/sqx_pipe_reg.sv
module sqx_pipe_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end

endmodule

// File: rtl/sqx_lane_zext.sv
module sqx_lane_zext
  import sqx_pkg::*;
#(
  parameter int unsigned LANE_W = 32,
  parameter int unsigned HALF_W = 16,
  parameter int unsigned DREG_W = 64
) (
  input  logic [SZ_W-1:0]   esize,
  input  logic [LANE_W-1:0] lane,
  output logic [DREG_W-1:0] dreg
);

  always_comb begin
    dreg = '0;
    if (esize == SZ_HALF) dreg[HALF_W-1:0] = lane[HALF_W-1:0];
    else                  dreg[LANE_W-1:0] = lane;
  end

endmodule

// File: rtl/sqx_decoder.sv
module sqx_decoder
  import sqx_pkg::*;
#(
  parameter int unsigned LANE_W = 32,
  parameter int unsigned HALF_W = 16,
  parameter int unsigned DREG_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [INSN_W-1:0] in_insn,
  input  logic              in_feat_en,
  input  logic              in_access_ok,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_hit,
  output logic              out_undef,
  output logic              out_trap,
  output logic              out_issue,
  output logic [RIDX_W-1:0] out_rd,
  output logic [RIDX_W-1:0] out_rn,
  output logic [RIDX_W-1:0] out_rm,
  output logic [SZ_W-1:0]   out_esize,
  output logic              out_sub,
  input  logic              res_valid,
  output logic              res_ready,
  input  logic [RIDX_W-1:0] res_rd,
  input  logic [SZ_W-1:0]   res_esize,
  input  logic [LANE_W-1:0] res_data,
  output logic              wb_valid,
  input  logic              wb_ready,
  output logic [RIDX_W-1:0] wb_rd,
  output logic [DREG_W-1:0] wb_data
);

  localparam int unsigned VERD_W = $bits(verdict_t);
  localparam int unsigned WB_W   = RIDX_W + DREG_W;

  logic     hit;
  fields_t  fld;
  verdict_e verd;
  logic     sub;
  verdict_t nxt;
  verdict_t cur;

  sqx_field_split u_split (
    .insn (in_insn),
    .hit  (hit),
    .f    (fld)
  );

  sqx_legal_chain u_chain (
    .hit       (hit),
    .f         (fld),
    .feat_en   (in_feat_en),
    .access_ok (in_access_ok),
    .verdict   (verd),
    .sub       (sub)
  );

  always_comb begin
    nxt.hit   = hit;
    nxt.undef = (verd == VERD_UNDEF);
    nxt.trap  = (verd == VERD_TRAP);
    nxt.issue = (verd == VERD_ISSUE);
    nxt.rd    = fld.rd;
    nxt.rn    = fld.rn;
    nxt.rm    = fld.rm;
    nxt.sz    = fld.sz;
    nxt.sub   = sub;
  end

  sqx_pipe_reg #(.W(VERD_W)) u_dec_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (nxt),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (cur)
  );

  assign out_hit   = cur.hit;
  assign out_undef = cur.undef;
  assign out_trap  = cur.trap;
  assign out_issue = cur.issue;
  assign out_rd    = cur.rd;
  assign out_rn    = cur.rn;
  assign out_rm    = cur.rm;
  assign out_esize = cur.sz;
  assign out_sub   = cur.sub;

  logic [DREG_W-1:0] ext;
  logic [WB_W-1:0]   wb_bus;

  sqx_lane_zext #(
    .LANE_W (LANE_W),
    .HALF_W (HALF_W),
    .DREG_W (DREG_W)
  ) u_zext (
    .esize (res_esize),
    .lane  (res_data),
    .dreg  (ext)
  );

  sqx_pipe_reg #(.W(WB_W)) u_wb_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (res_valid),
    .in_ready  (res_ready),
    .in_data   ({res_rd, ext}),
    .out_valid (wb_valid),
    .out_ready (wb_ready),
    .out_data  (wb_bus)
  );

  assign wb_rd   = wb_bus[WB_W-1 -: RIDX_W];
  assign wb_data = wb_bus[DREG_W-1:0];

endmodule

// File: rtl/sqx_decoder_chk.sv
module sqx_decoder_chk
  import sqx_pkg::*;
#(
  parameter int unsigned LANE_W = 32,
  parameter int unsigned HALF_W = 16,
  parameter int unsigned DREG_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic              out_hit,
  input logic              out_undef,
  input logic              out_trap,
  input logic              out_issue,
  input logic [RIDX_W-1:0] out_rd,
  input logic [RIDX_W-1:0] out_rn,
  input logic [RIDX_W-1:0] out_rm,
  input logic [SZ_W-1:0]   out_esize,
  input logic              out_sub,
  input logic              res_valid,
  input logic              res_ready,
  input logic [SZ_W-1:0]   res_esize,
  input logic              wb_valid,
  input logic              wb_ready,
  input logic [RIDX_W-1:0] wb_rd,
  input logic [DREG_W-1:0] wb_data
);

  p_miss_silent_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_hit |-> !(out_undef || out_trap || out_issue));

  p_issue_size_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_issue |-> (out_esize == SZ_HALF || out_esize == SZ_WORD));

  p_one_verdict_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_hit |-> $countones({out_undef, out_trap, out_issue}) == 1);

  p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid &&
      $stable({out_hit, out_undef, out_trap, out_issue, out_rd, out_rn, out_rm, out_esize, out_sub}));

  p_half_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_ready && res_esize == SZ_HALF |=> wb_data[DREG_W-1:HALF_W] == '0);

  p_word_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_ready |=> wb_data[DREG_W-1:LANE_W] == '0);

  p_wb_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid && !wb_ready |=> wb_valid && $stable(wb_data) && $stable(wb_rd));

endmodule

bind sqx_decoder sqx_decoder_chk #(
  .LANE_W (LANE_W),
  .HALF_W (HALF_W),
  .DREG_W (DREG_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_hit   (out_hit),
  .out_undef (out_undef),
  .out_trap  (out_trap),
  .out_issue (out_issue),
  .out_rd    (out_rd),
  .out_rn    (out_rn),
  .out_rm    (out_rm),
  .out_esize (out_esize),
  .out_sub   (out_sub),
  .res_valid (res_valid),
  .res_ready (res_ready),
  .res_esize (res_esize),
  .wb_valid  (wb_valid),
  .wb_ready  (wb_ready),
  .wb_rd     (wb_rd),
  .wb_data   (wb_data)
);

// File: tb/sqx_decoder_bench.sv
module sqx_decoder_bench;

  localparam int CLK_PERIOD = 10;
  localparam int N_CYCLES   = 4000;
  localparam int WD_LIMIT   = 20000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [31:0] in_insn;
  logic        in_feat_en;
  logic        in_access_ok;
  logic        out_valid;
  logic        out_ready;
  logic        out_hit, out_undef, out_trap, out_issue;
  logic [4:0]  out_rd, out_rn, out_rm;
  logic [1:0]  out_esize;
  logic        out_sub;
  logic        res_valid;
  logic        res_ready;
  logic [4:0]  res_rd;
  logic [1:0]  res_esize;
  logic [31:0] res_data;
  logic        wb_valid;
  logic        wb_ready;
  logic [4:0]  wb_rd;
  logic [63:0] wb_data;

  sqx_decoder u_sqx_decoder (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_insn(in_insn),
    .in_feat_en(in_feat_en), .in_access_ok(in_access_ok),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_hit(out_hit), .out_undef(out_undef), .out_trap(out_trap), .out_issue(out_issue),
    .out_rd(out_rd), .out_rn(out_rn), .out_rm(out_rm), .out_esize(out_esize), .out_sub(out_sub),
    .res_valid(res_valid), .res_ready(res_ready), .res_rd(res_rd),
    .res_esize(res_esize), .res_data(res_data),
    .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_rd(wb_rd), .wb_data(wb_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;

  // expected verdict layout: {hit, undef, trap, issue, rd, rn, rm, size, sub}
  logic [21:0] exp_q[$];
  string       tag_q[$];
  logic [68:0] wexp_q[$];

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  function automatic logic [31:0] mk(input int u, input int sz, input int op,
                                     input int rd, input int rn, input int rm);
    logic [31:0] w;
    w = 32'h5E00_8400;
    w[29]    = u[0];
    w[23:22] = sz[1:0];
    w[20:16] = rm[4:0];
    w[14:11] = op[3:0];
    w[9:5]   = rn[4:0];
    w[4:0]   = rd[4:0];
    return w;
  endfunction

  function automatic logic [21:0] ref_dec(input logic [31:0] w, input logic fe, input logic ac);
    bit hit, und, trp, iss, bad;
    int op, sz;
    hit = ((w & 32'hDF20_8400) == 32'h5E00_8400);
    op  = int'(w[14:11]);
    sz  = int'(w[23:22]);
    und = 0; trp = 0; iss = 0;
    if (hit) begin
      bad = (w[29] == 1'b0) || (op > 1) || (sz == 0) || (sz == 3) || !fe;
      if (bad) und = 1;
      else if (!ac) trp = 1;
      else iss = 1;
    end
    return {hit, und, trp, iss, w[4:0], w[9:5], w[20:16], w[23:22], (op == 1)};
  endfunction

  function automatic string ref_tag(input logic [31:0] w, input logic fe, input logic ac);
    if ((w & 32'hDF20_8400) != 32'h5E00_8400) return "R1";
    if (!w[29]) return "R3";
    if (w[14:11] > 4'd1) return "R4";
    if (w[23:22] == 2'd0 || w[23:22] == 2'd3) return "R5";
    if (!fe) return "R6";
    if (!ac) return "R7";
    return "R2";
  endfunction

  task automatic gen_item(input int k, output logic [31:0] w, output logic fe, output logic ac);
    fe = 1'b1; ac = 1'b1;
    case (k)
      0:  w = mk(1, 1, 0, 3, 7, 12);
      1:  w = mk(1, 2, 1, 31, 0, 17);
      2:  w = mk(0, 1, 0, 1, 2, 3);
      3:  w = mk(1, 1, 2, 4, 5, 6);
      4:  w = mk(1, 2, 15, 4, 5, 6);
      5:  w = mk(1, 0, 0, 8, 9, 10);
      6:  w = mk(1, 3, 1, 8, 9, 10);
      7:  begin w = mk(1, 2, 0, 11, 12, 13); fe = 1'b0; end
      8:  begin w = mk(1, 1, 1, 14, 15, 16); ac = 1'b0; end
      9:  begin w = mk(0, 1, 0, 14, 15, 16); ac = 1'b0; end
      10: begin w = mk(1, 2, 1, 14, 15, 16); ac = 1'b0; fe = 1'b0; end
      11: w = mk(1, 1, 0, 2, 2, 2) & ~32'h0000_0400;
      12: w = 32'h0;
      13: w = mk(1, 1, 0, 2, 2, 2) | 32'h0020_0000;
      default: begin
        if ($urandom % 8 == 0) w = $urandom;
        else w = mk(($urandom % 8 != 0) ? 1 : 0, $urandom % 4,
                    ($urandom % 4 == 0) ? $urandom % 16 : $urandom % 2,
                    $urandom % 32, $urandom % 32, $urandom % 32);
        fe = ($urandom % 10 != 0);
        ac = ($urandom % 6 != 0);
      end
    endcase
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  initial begin
    repeat (WD_LIMIT) @(posedge clk);
    n_fail++;
    $display("FAIL R8 watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    bit in_pend = 0;
    bit res_pend = 0;
    int k = 0;
    logic [31:0] w;
    logic fe, ac;
    logic [21:0] e;
    logic [21:0] a;
    logic [68:0] we;
    logic [31:0] lane;
    rst_n = 0; in_valid = 0; in_insn = 0; in_feat_en = 0; in_access_ok = 0;
    out_ready = 0; res_valid = 0; res_rd = 0; res_esize = 0; res_data = 0; wb_ready = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    chk(out_valid == 1'b0, "R8", "reset out_valid", 64'(out_valid), 64'd0);
    chk(wb_valid == 1'b0, "R11", "reset wb_valid", 64'(wb_valid), 64'd0);
    chk(in_ready == 1'b1, "R9", "reset in_ready", 64'(in_ready), 64'd1);

    for (int c = 0; c < N_CYCLES; c++) begin
      @(negedge clk);
      if (!in_pend) begin
        if ($urandom % 5 != 0) begin
          gen_item(k, w, fe, ac);
          k++;
          in_insn = w; in_feat_en = fe; in_access_ok = ac;
          in_valid = 1; in_pend = 1;
        end else in_valid = 0;
      end
      if (!res_pend) begin
        if ($urandom % 3 != 0) begin
          res_rd = 5'($urandom); res_esize = ($urandom % 2 == 0) ? 2'd1 : 2'd2;
          res_data = $urandom;
          res_valid = 1; res_pend = 1;
        end else res_valid = 0;
      end
      if ((c / 200) % 2 == 1) begin
        out_ready = ($urandom % 10 < 3);
        wb_ready  = ($urandom % 10 < 3);
      end else begin
        out_ready = ($urandom % 10 < 9);
        wb_ready  = ($urandom % 10 < 9);
      end
      #1;
      // decode stream
      chk(in_ready == (!out_valid || out_ready), "R9", "in_ready",
          64'(in_ready), 64'(!out_valid || out_ready));
      chk(out_valid == (exp_q.size() != 0), "R8", "out_valid",
          64'(out_valid), 64'(exp_q.size() != 0));
      if (out_valid && exp_q.size() != 0) begin
        e = exp_q[0];
        a = {out_hit, out_undef, out_trap, out_issue, out_rd, out_rn, out_rm, out_esize, out_sub};
        chk(a[21:18] == e[21:18], tag_q[0], "verdict flags", 64'(a[21:18]), 64'(e[21:18]));
        if (e[18])
          chk(a == e, tag_q[0], "issue fields", 64'(a), 64'(e));
        if (out_ready) begin
          void'(exp_q.pop_front());
          void'(tag_q.pop_front());
        end
      end
      if (in_valid && in_ready) begin
        exp_q.push_back(ref_dec(in_insn, in_feat_en, in_access_ok));
        tag_q.push_back(ref_tag(in_insn, in_feat_en, in_access_ok));
        in_pend = 0;
      end
      // writeback stream
      chk(res_ready == (!wb_valid || wb_ready), "R11", "res_ready",
          64'(res_ready), 64'(!wb_valid || wb_ready));
      chk(wb_valid == (wexp_q.size() != 0), "R11", "wb_valid",
          64'(wb_valid), 64'(wexp_q.size() != 0));
      if (wb_valid && wexp_q.size() != 0) begin
        we = wexp_q[0];
        chk(wb_data == we[63:0], "R10", "wb_data", wb_data, we[63:0]);
        chk(wb_rd == we[68:64], "R10", "wb_rd", 64'(wb_rd), 64'(we[68:64]));
        if (wb_ready) void'(wexp_q.pop_front());
      end
      if (res_valid && res_ready) begin
        lane = (res_esize == 2'd1) ? (res_data & 32'h0000_FFFF) : res_data;
        wexp_q.push_back({res_rd, 32'h0, lane});
        res_pend = 0;
      end
    end
    summary();
    $finish;
  end

endmodule